// File: doc/BRIEF.md
# Reloadable Down-Counting Timer Channel

This block is one channel of a general-purpose timer. A shared prescaler elsewhere in the chip produces a one-cycle tick strobe. On each tick the channel decrements its counter while it is enabled. The channel expires only when a tick arrives with the counter already at zero, so it underflows past zero rather than stopping on it.

On expiry the channel can do two things. It can latch a sticky pending flag and emit a single interrupt pulse. It can also copy its reload value back into the counter and keep running. Without the reload, it switches itself off.

Software-side logic drives three write strobes that share one data bus: the count, the reload value and the control word. It reads all three back on dedicated outputs. Two control bits, chaining and debug halt, are only stored so that software sees them again. They change nothing in the channel's behaviour.

Top module: `dctmr_channel`

## Requirements
- R1: After reset the count, the reload value and the control word read 0 and the interrupt output is low.
- R2: While enable (control bit 0) is 1, each tick with no write in that cycle lowers the count by one if it is nonzero. A start value of N therefore expires on the (N+1)th tick.
- R3: An expiry with interrupt enable (control bit 3) set does two things. It sets pending (control bit 4), and it drives the interrupt output high for exactly the one cycle after the expiring tick.
- R4: On expiry with restart (control bit 1) set, the count takes the reload value and counting continues. Without restart, the count stays 0 and enable clears to 0.
- R5: A control write with data bit 4 = 1 clears pending. A control write with data bit 4 = 0 leaves pending unchanged. All other control bits take the written data.
- R6: A control write with load (data bit 2) = 1 copies the reload value into the count. The load bit always reads back as 0.
- R7: A counter write sets the count to the write data.
- R8: While enable is 0, ticks are ignored and the count holds.
- R9: Any write in a cycle blocks that cycle's tick. A counter write beats a load in the same cycle. A load in the same cycle as a reload write copies the old reload value.
- R10: Chain (control bit 5) and debug halt (control bit 6) are stored and read back but do not change counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaler tick strobe |
| cnt_we_i | input | 1 | Counter write strobe |
| rld_we_i | input | 1 | Reload write strobe |
| ctl_we_i | input | 1 | Control write strobe |
| wdata_i | input | CNT_W | Shared write data |
| cnt_o | output | CNT_W | Current count |
| rld_o | output | CNT_W | Reload value |
| ctl_o | output | 7 | Control word readback |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest state to reach from the ports is a tick that coincides with a write while the counter already sits at zero. The tick has to be suppressed there, and a sticky pending flag has to survive writes that do not clear it. The stimulus first walks the channel through directed sequences. These include one-shot expiry, periodic reload, a clear write overlapping a tick, counter and load writes in one cycle, and reload and load writes in one cycle. A long stretch then follows with small random counts and reload values, so that zero-count expiries collide with writes often. A behavioural model is compared with the design on every clock.

// File: rtl/dctmr_pkg.sv
package dctmr_pkg;
   localparam int CTL_W = 7;
   localparam int B_EN    = 0;
   localparam int B_RST   = 1;
   localparam int B_LOAD  = 2;
   localparam int B_IEN   = 3;
   localparam int B_PEND  = 4;
   localparam int B_CHAIN = 5;
   localparam int B_HALT  = 6;

   typedef struct packed {
      logic halt;
      logic chain;
      logic pend;
      logic ien;
      logic load;
      logic rst;
      logic en;
   } tmr_ctl_t;
endpackage

// File: rtl/dctmr_ctl_reg.sv
module dctmr_ctl_reg
   import dctmr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we_i,
   input  logic [CTL_W-1:0] wdata_i,
   input  logic             expire_i,
   output tmr_ctl_t         ctl_o,
   output logic             irq_set_o
);
   tmr_ctl_t ctl_q, ctl_d, wr_val;

   always_comb begin
      wr_val      = tmr_ctl_t'(wdata_i);
      wr_val.load = 1'b0;
      wr_val.pend = wdata_i[B_PEND] ? 1'b0 : ctl_q.pend;
   end

   always_comb begin
      ctl_d = ctl_q;
      if (ctl_we_i) begin
         ctl_d = wr_val;
      end else if (expire_i) begin
         if (ctl_q.ien) ctl_d.pend = 1'b1;
         if (!ctl_q.rst) ctl_d.en = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_q <= '0;
      else        ctl_q <= ctl_d;
   end

   assign ctl_o     = ctl_q;
   assign irq_set_o = expire_i & ctl_q.ien;
endmodule

// File: rtl/dctmr_down_cnt.sv
module dctmr_down_cnt #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             any_we_i,
   input  logic             cnt_we_i,
   input  logic             rld_we_i,
   input  logic             load_i,
   input  logic             en_i,
   input  logic             restart_i,
   input  logic [CNT_W-1:0] wdata_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] rld_o,
   output logic             expire_o
);
   localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
   localparam logic [CNT_W-1:0] ZERO = '0;

   logic [CNT_W-1:0] cnt_q, cnt_d, rld_q;
   logic             step;
   logic             at_zero;

   assign step     = tick_i & en_i & ~any_we_i;
   assign at_zero  = (cnt_q == ZERO);
   assign expire_o = step & at_zero;

   always_comb begin
      cnt_d = cnt_q;
      if (cnt_we_i)      cnt_d = wdata_i;
      else if (load_i)   cnt_d = rld_q;
      else if (step) begin
         if (!at_zero)       cnt_d = cnt_q - ONE;
         else if (restart_i) cnt_d = rld_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         rld_q <= '0;
      end else begin
         cnt_q <= cnt_d;
         if (rld_we_i) rld_q <= wdata_i;
      end
   end

   assign cnt_o = cnt_q;
   assign rld_o = rld_q;
endmodule

// File: rtl/dctmr_channel.sv
module dctmr_channel
   import dctmr_pkg::*;
#(
   parameter int CNT_W   = 32,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             cnt_we_i,
   input  logic             rld_we_i,
   input  logic             ctl_we_i,
   input  logic [CNT_W-1:0] wdata_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] rld_o,
   output logic [6:0]       ctl_o,
   output logic             irq_o
);
   initial begin
      assert (CNT_W >= 8 && CNT_W <= 64)
         else $error("dctmr_channel: CNT_W must lie in 8..64");
   end

   tmr_ctl_t ctl;
   logic     any_we, expire, irq_set, load_req;

   assign any_we   = cnt_we_i | rld_we_i | ctl_we_i;
   assign load_req = ctl_we_i & wdata_i[B_LOAD];

   dctmr_ctl_reg u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_we_i  (ctl_we_i),
      .wdata_i   (wdata_i[CTL_W-1:0]),
      .expire_i  (expire),
      .ctl_o     (ctl),
      .irq_set_o (irq_set)
   );

   dctmr_down_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_i),
      .any_we_i  (any_we),
      .cnt_we_i  (cnt_we_i),
      .rld_we_i  (rld_we_i),
      .load_i    (load_req),
      .en_i      (ctl.en),
      .restart_i (ctl.rst),
      .wdata_i   (wdata_i),
      .cnt_o     (cnt_o),
      .rld_o     (rld_o),
      .expire_o  (expire)
   );

   generate
      if (IRQ_REG) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_set;
         end
         assign irq_o = irq_q;
      end else begin : g_irq_comb
         assign irq_o = irq_set;
      end
   endgenerate

   assign ctl_o = ctl;
endmodule

// File: rtl/dctmr_chk.sv
module dctmr_chk #(
   parameter int CNT_W   = 32,
   parameter bit IRQ_REG = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_i,
   input logic             cnt_we_i,
   input logic             rld_we_i,
   input logic             ctl_we_i,
   input logic [CNT_W-1:0] wdata_i,
   input logic [CNT_W-1:0] cnt_o,
   input logic [CNT_W-1:0] rld_o,
   input logic [6:0]       ctl_o,
   input logic             irq_o
);
   logic quiet;
   assign quiet = !cnt_we_i && !rld_we_i && !ctl_we_i;

   p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_o[0] && tick_i && quiet && cnt_o != '0) |=> cnt_o == $past(cnt_o) - 1);

   p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_o[0] && ctl_o[1] && tick_i && quiet && cnt_o == '0) |=> cnt_o == $past(rld_o));

   p_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_o[0] && !ctl_o[1] && tick_i && quiet && cnt_o == '0) |=> !ctl_o[0]);

   p_pend_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_o[4] && !(ctl_we_i && wdata_i[4])) |=> ctl_o[4]);

   p_pend_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we_i && wdata_i[4]) |=> !ctl_o[4]);

   p_hold_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_o[0] && !cnt_we_i && !ctl_we_i) |=> $stable(cnt_o));

   p_tick_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rld_we_i && !cnt_we_i && !ctl_we_i) |=> $stable(cnt_o));

   generate
      if (IRQ_REG) begin : g_irq_chk
         p_irq_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o |-> ctl_o[4]);
      end
   endgenerate
endmodule

bind dctmr_channel dctmr_chk #(.CNT_W(CNT_W), .IRQ_REG(IRQ_REG)) u_chk (.*);

// File: tb/sim_dctmr_channel.sv
module sim_dctmr_channel;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0, cwe = 1'b0, rwe = 1'b0, twe = 1'b0;
   logic [31:0] wd = '0;
   logic [31:0] cnt, rld;
   logic [6:0]  ctl;
   logic        irq;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   dctmr_channel u0 (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .cnt_we_i(cwe), .rld_we_i(rwe),
      .ctl_we_i(twe), .wdata_i(wd), .cnt_o(cnt), .rld_o(rld), .ctl_o(ctl), .irq_o(irq)
   );

   // behavioural reference model
   logic [31:0] m_cnt = '0, m_rld = '0, old_rld;
   logic [6:0]  m_ctl = '0;
   logic        m_irq = 1'b0, nirq;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_rld = 0; m_ctl = 0; m_irq = 0;
      end else begin
         nirq = 1'b0;
         old_rld = m_rld;
         if (twe) begin
            logic p;
            p = wd[4] ? 1'b0 : m_ctl[4];
            m_ctl = wd[6:0];
            m_ctl[2] = 1'b0;
            m_ctl[4] = p;
            if (wd[2]) m_cnt = old_rld;
         end
         if (rwe) m_rld = wd;
         if (cwe) m_cnt = wd;
         if (!(twe || rwe || cwe) && tick && m_ctl[0]) begin
            if (m_cnt == 0) begin
               if (m_ctl[3]) begin m_ctl[4] = 1'b1; nirq = 1'b1; end
               if (m_ctl[1]) m_cnt = m_rld;
               else m_ctl[0] = 1'b0;
            end else begin
               m_cnt = m_cnt - 1;
            end
         end
         m_irq = nirq;
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(cur_req, "model cnt", cnt, m_cnt);
         chk(cur_req, "model rld", rld, m_rld);
         chk(cur_req, "model ctl", {25'd0, ctl}, {25'd0, m_ctl});
         chk(cur_req, "model irq", {31'd0, irq}, {31'd0, m_irq});
      end
   end

   task automatic finish_up;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected=<150000", cycles);
         finish_up();
      end
   end

   task automatic step(input logic t, input logic c, input logic r, input logic w, input logic [31:0] d);
      @(negedge clk);
      tick = t; cwe = c; rwe = r; twe = w; wd = d;
   endtask

   task automatic idle;
      step(0, 0, 0, 0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "reset cnt", cnt, 0);
      chk("R1", "reset rld", rld, 0);
      chk("R1", "reset ctl", {25'd0, ctl}, 0);
      chk("R1", "reset irq", {31'd0, irq}, 0);
      rst_n = 1'b1;

      cur_req = "R7";
      step(0, 0, 1, 0, 3);
      step(0, 1, 0, 0, 2);
      step(0, 0, 0, 1, 32'h09);
      idle;
      chk("R7", "count written", cnt, 2);

      cur_req = "R2";
      step(1, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0);
      idle;
      chk("R2", "two ticks from 2", cnt, 0);
      chk("R2", "no expiry at zero", {31'd0, irq}, 0);
      cur_req = "R3";
      step(1, 0, 0, 0, 0);
      idle;
      chk("R3", "irq after third tick", {31'd0, irq}, 1);
      chk("R4", "one-shot stops, pend set", {25'd0, ctl}, 32'h18);
      idle;
      chk("R3", "irq single pulse", {31'd0, irq}, 0);

      cur_req = "R8";
      step(0, 1, 0, 0, 5);
      step(1, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0);
      idle;
      chk("R8", "disabled hold", cnt, 5);

      cur_req = "R5";
      step(0, 0, 0, 1, 32'h08);
      idle;
      chk("R5", "pend kept", {25'd0, ctl}, 32'h18);
      step(0, 0, 0, 1, 32'h18);
      idle;
      chk("R5", "pend cleared", {25'd0, ctl}, 32'h08);

      cur_req = "R6";
      step(0, 0, 1, 0, 4);
      step(0, 0, 0, 1, 32'h0F);
      idle;
      chk("R6", "load copies reload", cnt, 4);
      chk("R6", "load reads zero", {25'd0, ctl}, 32'h0B);

      cur_req = "R4";
      for (int i = 0; i < 10; i++) step(1, 0, 0, 0, 0);
      idle;
      chk("R4", "periodic reload", cnt, 4);
      chk("R3", "periodic irq", {31'd0, irq}, 1);

      cur_req = "R9";
      step(1, 0, 0, 1, 32'h1B);
      idle;
      chk("R9", "tick blocked by write", cnt, 4);
      step(1, 1, 0, 1, 32'h0F);
      idle;
      chk("R9", "counter write beats load", cnt, 32'h0F);
      step(0, 0, 1, 1, 32'h0F);
      idle;
      chk("R9", "load takes old reload", cnt, 4);
      chk("R9", "reload written", rld, 32'h0F);

      cur_req = "R10";
      step(0, 0, 0, 1, 32'h61);
      step(1, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0);
      idle;
      chk("R10", "chain/halt ignored", cnt, 2);
      chk("R10", "chain/halt stored", {25'd0, ctl}, 32'h61);

      cur_req = "R2";
      for (int i = 0; i < 3000; i++) begin
         int sel;
         sel = $urandom_range(0, 19);
         if (sel == 0)      step($urandom_range(0, 1), 1, 0, 0, $urandom_range(0, 4));
         else if (sel == 1) step($urandom_range(0, 1), 0, 1, 0, $urandom_range(0, 3));
         else if (sel == 2) step($urandom_range(0, 1), 0, 0, 1, $urandom_range(0, 127));
         else if (sel == 3) step(1, 0, 0, 1, 32'h0B);
         else               step($urandom_range(0, 1), 0, 0, 0, 0);
      end
      idle;
      idle;
      finish_up();
   end
endmodule